// File: doc/BRIEF.md
# Counter Array Timebase Controller

This block is the shared 16-bit timebase for a bank of compare/capture modules inside an 8-bit microcontroller. Software reaches it through a byte-wide register port with four addresses: a mode register, a control register, and the low and high bytes of the counter. The counter advances on pulses from one of four sources: the oscillator divided by twelve, the oscillator divided by four, overflow pulses from timer 0, or falling edges seen on an external pin after synchronization. Counting needs the run bit. The counter can also be frozen while the core is idle.

When the counter wraps from FFFFh to 0000h it sets a sticky overflow flag, and that flag can drive an interrupt. The control register also holds five flags, one for each compare/capture module. Each is set by a pulse from its module and cleared by software. The watchdog-enable bit in the mode register is passed straight out to module 4.

Top module: `pca_timebase`

## Requirements
- R1: After reset all four registers read 00h, and both `irq` and `wdog_en` are 0.
- R2: Address 0 is the mode register, laid out as {idle_gate[7], wdog[6], 000, src[2:1], ecf[0]}. Address 1 is the control register, laid out as {ovf[7], run[6], 0, mflag[4:0]}. Addresses 2 and 3 hold the counter's low and high bytes. Reserved bits always read 0. A read returns data one clock after the address is presented.
- R3: With src=00 the counter gains one count every 12 clocks. With src=01 it gains one count every 4 clocks.
- R4: With src=10 every clock in which `t0_ovf` is high adds one count. With src=11 every falling edge of `ext_pin` adds one count, after a two-flop synchronizer and within four clocks.
- R5: While run=0 the counter holds its value.
- R6: With idle_gate=1, the counter holds while `idle_mode` is high. With idle_gate=0, `idle_mode` has no effect on counting.
- R7: Both counter bytes can be written directly, and in the same cycle a write wins over a count. A count at FFFFh wraps the counter to 0000h and sets ovf.
- R8: Writing 1 to ovf sets it, and only writing 0 clears it. If a wrap and a clearing write fall in the same cycle, ovf ends up 1.
- R9: `irq` is high exactly while ovf=1 and ecf=1.
- R10: A high `mod_hit[i]` sets mflag[i]. Writing 0 to that bit clears it, and writing 1 leaves it unchanged. If a hit and a clear fall in the same cycle, the flag ends up 1.
- R11: `wdog_en` follows mode bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| idle_mode | input | 1 | Core idle indication |
| t0_ovf | input | 1 | Timer 0 overflow pulse |
| ext_pin | input | 1 | Asynchronous external count pin |
| mod_hit | input | 5 | Per-module match/capture set pulses |
| irq | output | 1 | Overflow interrupt |
| wdog_en | output | 1 | Watchdog enable to module 4 |

## Verification
Two pairs of events can land in the same cycle, and each pair sets and clears the same flag. A counter wrap can coincide with a software write that clears ovf, and a module hit pulse can coincide with a write of 0 to that module's flag. The bench forces each collision by raising the `t0_ovf` or `mod_hit` pulse on the exact clock that carries the control-register write. It then reads the register back and expects the set to have won. For the module flags it also expects the untouched bits to have been cleared.

// File: rtl/pca_timebase_pkg.sv
package pca_timebase_pkg;
  typedef enum logic [1:0] {
    REG_MODE   = 2'd0,
    REG_CTRL   = 2'd1,
    REG_CNT_LO = 2'd2,
    REG_CNT_HI = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    SRC_DIV_SLOW = 2'd0,
    SRC_DIV_FAST = 2'd1,
    SRC_TIMER    = 2'd2,
    SRC_PIN      = 2'd3
  } src_sel_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/pca_tick_src.sv
module pca_tick_src
  import pca_timebase_pkg::*;
#(
  parameter int PRE_SLOW    = 12,
  parameter int PRE_FAST    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  src_sel_e sel,
  input  logic     tmr_pulse,
  input  logic     pin_async,
  output logic     tick
);
  localparam int SW = $clog2(PRE_SLOW);
  localparam int FW = $clog2(PRE_FAST);

  logic [SW-1:0] slow_q;
  logic [FW-1:0] fast_q;
  logic          tick_slow, tick_fast;

  assign tick_slow = (slow_q == SW'(PRE_SLOW - 1));
  assign tick_fast = (fast_q == FW'(PRE_FAST - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      slow_q <= '0;
      fast_q <= '0;
    end else begin
      slow_q <= tick_slow ? '0 : slow_q + SW'(1);
      fast_q <= tick_fast ? '0 : fast_q + FW'(1);
    end
  end

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_prev_q;
  logic                   pin_fall;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= pin_async;
      end
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_async};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) pin_prev_q <= 1'b0;
    else     pin_prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign pin_fall = pin_prev_q & ~sync_q[SYNC_STAGES-1];

  always_comb begin
    case (sel)
      SRC_DIV_SLOW: tick = tick_slow;
      SRC_DIV_FAST: tick = tick_fast;
      SRC_TIMER:    tick = tmr_pulse;
      default:      tick = pin_fall;
    endcase
  end

  // R3: the divided-oscillator ticks never come on back-to-back clocks
  assert_slow_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    tick_slow |=> !tick_slow);
  assert_fast_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    tick_fast |=> !tick_fast);
  // R4: a falling edge of the synchronized pin gives a one-clock pulse
  assert_pin_single_R4: assert property (@(posedge clk) disable iff (rst)
    pin_fall |=> !pin_fall);
endmodule

// File: rtl/pca_cnt16.sv
module pca_cnt16
  import pca_timebase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              count_en,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt,
  output logic              wrap
);
  localparam int HI_W = CNT_W - BYTE_W;

  logic any_wr;
  assign any_wr = wr_lo | wr_hi;
  assign wrap   = count_en & (&cnt) & ~any_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (any_wr) begin
      if (wr_lo) cnt[BYTE_W-1:0]     <= wdata;
      if (wr_hi) cnt[CNT_W-1:BYTE_W] <= wdata[HI_W-1:0];
    end else if (count_en) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // R7: a count steps the value by one, wrapping at the top
  assert_step_R7: assert property (@(posedge clk) disable iff (rst)
    (count_en && !any_wr) |=> cnt == $past(cnt) + CNT_W'(1));
  // R5: without a count or a write the value is held
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!count_en && !any_wr) |=> $stable(cnt));
  // R7: a wrap lands on zero
  assert_wrap_zero_R7: assert property (@(posedge clk) disable iff (rst)
    wrap |=> cnt == '0);
endmodule

// File: rtl/pca_flags.sv
module pca_flags #(
  parameter int NMOD = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_ctrl,
  input  logic            wr_ovf,
  input  logic            wr_run,
  input  logic [NMOD-1:0] wr_mflag,
  input  logic            wrap,
  input  logic [NMOD-1:0] hit,
  output logic            ovf,
  output logic            ovf_d,
  output logic            run,
  output logic [NMOD-1:0] mflag
);
  // hardware set has priority over a software clear
  assign ovf_d = wrap | (wr_ctrl ? wr_ovf : ovf);

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf <= 1'b0;
      run <= 1'b0;
    end else begin
      ovf <= ovf_d;
      if (wr_ctrl) run <= wr_run;
    end
  end

  generate
    for (genvar i = 0; i < NMOD; i++) begin : g_mflag
      always_ff @(posedge clk) begin
        if (rst)          mflag[i] <= 1'b0;
        else if (hit[i])  mflag[i] <= 1'b1;
        else if (wr_ctrl) mflag[i] <= mflag[i] & wr_mflag[i];
      end

      // R10: hit sets the flag, and only a write can drop it
      assert_mflag_set_R10: assert property (@(posedge clk) disable iff (rst)
        hit[i] |=> mflag[i]);
      assert_mflag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (mflag[i] && !wr_ctrl) |=> mflag[i]);
    end
  endgenerate

  // R8: ovf is sticky and a wrap always leaves it set
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (ovf && !wr_ctrl) |=> ovf);
  assert_ovf_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    wrap |=> ovf);
endmodule

// File: rtl/pca_timebase.sv
module pca_timebase
  import pca_timebase_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int NMOD        = 5,
  parameter int PRE_SLOW    = 12,
  parameter int PRE_FAST    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      bus_addr,
  input  logic            bus_wr,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  input  logic            idle_mode,
  input  logic            t0_ovf,
  input  logic            ext_pin,
  input  logic [NMOD-1:0] mod_hit,
  output logic            irq,
  output logic            wdog_en
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(bus_addr);

  logic wr_mode, wr_ctrl, wr_lo, wr_hi, cnt_wr;
  assign wr_mode = bus_wr && (sel == REG_MODE);
  assign wr_ctrl = bus_wr && (sel == REG_CTRL);
  assign wr_lo   = bus_wr && (sel == REG_CNT_LO);
  assign wr_hi   = bus_wr && (sel == REG_CNT_HI);
  assign cnt_wr  = wr_lo | wr_hi;

  // mode register
  logic     idle_gate_q, ecf_q, ecf_d;
  src_sel_e src_q;

  assign ecf_d = wr_mode ? bus_wdata[0] : ecf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_gate_q <= 1'b0;
      wdog_en     <= 1'b0;
      src_q       <= SRC_DIV_SLOW;
      ecf_q       <= 1'b0;
    end else if (wr_mode) begin
      idle_gate_q <= bus_wdata[7];
      wdog_en     <= bus_wdata[6];
      src_q       <= src_sel_e'(bus_wdata[2:1]);
      ecf_q       <= bus_wdata[0];
    end
  end

  // count pulse selection
  logic tick;
  pca_tick_src #(
    .PRE_SLOW   (PRE_SLOW),
    .PRE_FAST   (PRE_FAST),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_tick (
    .clk      (clk),
    .rst      (rst),
    .sel      (src_q),
    .tmr_pulse(t0_ovf),
    .pin_async(ext_pin),
    .tick     (tick)
  );

  logic run, ovf, ovf_d, wrap, count_en;
  logic [NMOD-1:0]  mflag;
  logic [CNT_W-1:0] cnt;

  assign count_en = run & tick & ~(idle_gate_q & idle_mode);

  pca_cnt16 #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .count_en(count_en),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .wdata   (bus_wdata),
    .cnt     (cnt),
    .wrap    (wrap)
  );

  pca_flags #(.NMOD(NMOD)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .wr_ctrl (wr_ctrl),
    .wr_ovf  (bus_wdata[7]),
    .wr_run  (bus_wdata[6]),
    .wr_mflag(bus_wdata[NMOD-1:0]),
    .wrap    (wrap),
    .hit     (mod_hit),
    .ovf     (ovf),
    .ovf_d   (ovf_d),
    .run     (run),
    .mflag   (mflag)
  );

  // registered interrupt, built from next-state values so it tracks the flags
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= ovf_d & ecf_d;
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (sel)
        REG_MODE:   bus_rdata <= {idle_gate_q, wdog_en, 3'b000, src_q, ecf_q};
        REG_CTRL:   bus_rdata <= {ovf, run, 1'b0, mflag};
        REG_CNT_LO: bus_rdata <= cnt[7:0];
        default:    bus_rdata <= cnt[CNT_W-1:8];
      endcase
    end
  end

  // R9: interrupt mirrors the flag and its enable
  assert_irq_match_R9: assert property (@(posedge clk) disable iff (rst)
    irq == (ovf & ecf_q));
  // R5: stopped counter does not move
  assert_run_gate_R5: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_wr) |=> $stable(cnt));
  // R6: gated idle freezes the counter
  assert_idle_gate_R6: assert property (@(posedge clk) disable iff (rst)
    (idle_gate_q && idle_mode && !cnt_wr) |=> $stable(cnt));
  // R2: reserved bits of the read port stay zero
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    $past(sel == REG_MODE) |-> bus_rdata[5:3] == 3'b000);
endmodule

// File: tb/sim_pca_timebase.sv
module sim_pca_timebase;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       idle_mode = 1'b0;
  logic       t0_ovf = 1'b0;
  logic       ext_pin = 1'b0;
  logic [4:0] mod_hit = '0;
  logic       irq, wdog_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pca_timebase u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .idle_mode(idle_mode),
    .t0_ovf(t0_ovf), .ext_pin(ext_pin), .mod_hit(mod_hit),
    .irq(irq), .wdog_en(wdog_en)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_range(string req, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic rd_cnt(output int v);
    logic [7:0] lo, hi;
    rd(2'd2, lo);
    rd(2'd3, hi);
    v = {hi, lo};
  endtask

  task automatic set_cnt(input int v);
    wr(2'd2, v[7:0]);
    wr(2'd3, v[15:8]);
  endtask

  task automatic t0_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); t0_ovf = 1'b1;
      @(negedge clk); t0_ovf = 1'b0;
    end
  endtask

  function automatic int next_cnt(int c, bit run, bit gate, bit idle, bit pulse);
    if (run && pulse && !(gate && idle)) return (c + 1) & 16'hFFFF;
    return c;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int v, base, model;
    bit gate;
    logic [4:0] mf;
    void'($urandom(32'h5eed_1234));

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(2'd0, d); chk("R1 mode", d, 8'h00);
    rd(2'd1, d); chk("R1 ctrl", d, 8'h00);
    rd_cnt(v);   chk("R1 counter", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 wdog", wdog_en, 0);

    // R2 / R11 reserved bits and watchdog enable
    wr(2'd0, 8'hFF);
    rd(2'd0, d); chk("R2 mode reserved", d, 8'hC7);
    chk("R11 wdog on", wdog_en, 1);
    wr(2'd0, 8'h00);
    @(negedge clk); chk("R11 wdog off", wdog_en, 0);

    // R7 direct counter write
    set_cnt(16'h1234);
    rd_cnt(v); chk("R7 write bytes", v, 16'h1234);

    // R4 timer source
    wr(2'd0, 8'h04);
    wr(2'd1, 8'h40);
    t0_pulses(7);
    rd_cnt(v); chk("R4 timer count", v, 16'h1234 + 7);

    // R5 run gating
    wr(2'd1, 8'h00);
    t0_pulses(5);
    rd_cnt(v); chk("R5 stopped", v, 16'h1234 + 7);

    // R6 idle gate
    wr(2'd0, 8'h84);
    wr(2'd1, 8'h40);
    idle_mode = 1'b1;
    t0_pulses(4);
    rd_cnt(v); chk("R6 gated idle", v, 16'h1234 + 7);
    idle_mode = 1'b0;
    t0_pulses(2);
    rd_cnt(v); chk("R6 gated awake", v, 16'h1234 + 9);
    wr(2'd0, 8'h04);
    idle_mode = 1'b1;
    t0_pulses(3);
    idle_mode = 1'b0;
    rd_cnt(v); chk("R6 ungated idle", v, 16'h1234 + 12);

    // R4 external pin, falling edges
    base = 16'h1234 + 12;
    wr(2'd0, 8'h06);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); ext_pin = 1'b1;
      repeat (4) @(negedge clk);
      ext_pin = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    rd_cnt(v); chk("R4 pin edges", v, base + 5);

    // R3 divided oscillator sources
    wr(2'd1, 8'h00);
    set_cnt(0);
    wr(2'd0, 8'h02);
    wr(2'd1, 8'h40);
    repeat (39) @(negedge clk);
    wr(2'd1, 8'h00);
    rd_cnt(v); chk_range("R3 div4", v, 9, 11);
    set_cnt(0);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h40);
    repeat (119) @(negedge clk);
    wr(2'd1, 8'h00);
    rd_cnt(v); chk_range("R3 div12", v, 9, 11);

    // R7 / R8 / R9 rollover with interrupt
    wr(2'd0, 8'h05);
    set_cnt(16'hFFFF);
    wr(2'd1, 8'h40);
    t0_pulses(1);
    rd(2'd1, d); chk("R7 rollover sets ovf", d, 8'hC0);
    rd_cnt(v); chk("R7 wrap to zero", v, 0);
    chk("R9 irq on", irq, 1);

    // R8 software clear, software set; R9 enable
    wr(2'd1, 8'h40);
    chk("R9 irq off after clear", irq, 0);
    rd(2'd1, d); chk("R8 clear by write 0", d, 8'h40);
    wr(2'd1, 8'hC0);
    rd(2'd1, d); chk("R8 set by software", d, 8'hC0);
    chk("R9 irq on sw set", irq, 1);
    wr(2'd0, 8'h04);
    chk("R9 irq masked", irq, 0);

    // R8 conflict: wrap and clearing write in one cycle
    wr(2'd1, 8'h40);
    set_cnt(16'hFFFF);
    @(negedge clk);
    bus_addr = 2'd1; bus_wdata = 8'h40; bus_wr = 1'b1; t0_ovf = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; t0_ovf = 1'b0;
    rd(2'd1, d); chk("R8 wrap beats clear", d, 8'hC0);

    // R10 module flags
    wr(2'd1, 8'h40);
    @(negedge clk); mod_hit = 5'b10101;
    @(negedge clk); mod_hit = 5'b00000;
    rd(2'd1, d); chk("R10 hit sets", d & 8'h1F, 8'h15);
    wr(2'd1, 8'h5F);
    rd(2'd1, d); chk("R10 write 1 keeps", d & 8'h1F, 8'h15);
    wr(2'd1, 8'h50);
    rd(2'd1, d); chk("R10 write 0 clears", d & 8'h1F, 8'h10);
    @(negedge clk);
    bus_addr = 2'd1; bus_wdata = 8'h40; bus_wr = 1'b1; mod_hit = 5'b00001;
    @(negedge clk);
    bus_wr = 1'b0; mod_hit = 5'b00000;
    rd(2'd1, d); chk("R10 hit beats clear", d & 8'h1F, 8'h01);

    // random rounds: timer source, random idle and gate, random hits
    for (int r = 0; r < 6; r++) begin
      gate = 1'($urandom);
      wr(2'd1, 8'h00);
      set_cnt(0);
      wr(2'd0, gate ? 8'h84 : 8'h04);
      wr(2'd1, 8'h40);
      model = 0;
      mf = '0;
      for (int c = 0; c < 300; c++) begin
        @(negedge clk);
        idle_mode = 1'($urandom);
        t0_ovf    = 1'($urandom);
        mod_hit   = (($urandom % 8) == 0) ? 5'($urandom) : 5'b0;
        model = next_cnt(model, 1'b1, gate, idle_mode, t0_ovf);
        mf = mf | mod_hit;
      end
      @(negedge clk);
      idle_mode = 1'b0; t0_ovf = 1'b0; mod_hit = '0;
      rd_cnt(v); chk(gate ? "R6 random gated count" : "R4 random count", v, model);
      rd(2'd1, d); chk("R10 random flags", d & 8'h1F, mf);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule